// File: doc/BRIEF.md
# Programmable Serial Receive Character Assembler

This block collects serial receive bits, one per strobe, and hands finished bytes to a downstream receive FIFO. The character length is set by a two-bit code (5 to 8 data bits) and can be stretched by one bit when parity is enabled, so a character is 5 to 9 bits long. Bits arrive least significant first and enter a 9-bit shift register at its top end. Parity checking and CRC are handled elsewhere.

The byte it produces depends on the framing mode. In asynchronous mode each character yields one byte, right-justified, with every bit above the character set to one. In the two synchronous framings (character-synchronous and bit-oriented frame mode) the block emits the most recent eight bits of the stream each time the bit count reaches the character length. With characters shorter than eight bits, the top bits of one byte therefore reappear as the low bits of the next byte.

The receiver runs when its enable is set. When the carrier-gating control is also set, the active-low carrier-detect input becomes a second condition, and the receiver runs only while that input is low. Carrier-detect is always registered and shown as a status output. A two-state controller tracks whether the receiver is running. RX_OFF holds the bit counter clear and ignores bits. Transition GO moves it to RX_ASM once the receiver is enabled. RX_ASM accepts bits, and transition STOP returns it to RX_OFF when the enable falls.

Top module: `rx_char_assembler`

## Requirements
- R1: While reset is asserted, byte_push is 0, byte_out is 8'h00 and dcd_status is 1, whatever the level of dcd_n.
- R2: len_code 2'b00, 2'b01, 2'b10 and 2'b11 select 5, 6, 7 and 8 bits per character. par_en=1 adds one bit (6 to 9). A push follows exactly the accepted bit that completes the character, and two pushes are never in adjacent cycles.
- R3: With mode 2'b00 (asynchronous), byte_out bit i holds the i-th received bit of the character (bit 0 first) for i below the length, and 1 above it. A 9-bit character delivers its first eight bits.
- R4: With mode 2'b01 (character-synchronous), 2'b10 (bit-oriented frame) or 2'b11 (treated as character-synchronous), each push delivers the last eight accepted bits, the newest in bit 7. Bits from earlier characters therefore fill the low positions when the length is below eight.
- R5: A change of len_code or par_en during a character takes effect on the next accepted bit. If the bit count already equals or exceeds the new length, the character ends on that next bit, with as many bits as were accepted.
- R6: When the receiver is not running, bits are ignored, the shift history is unchanged and the bit counter is cleared. After re-enabling, a new character starts from the first accepted bit.
- R7: With auto_en=1, the receiver runs only while rx_en=1 and the registered dcd_n is 0. With auto_en=0, dcd_n has no effect on reception.
- R8: dcd_status equals dcd_n delayed by one clock.
- R9: byte_push is a single-cycle pulse in the cycle after the completing bit_valid, and byte_out is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial receive bit |
| bit_valid | input | 1 | bit_in is valid this cycle |
| len_code | input | 2 | Character length code |
| par_en | input | 1 | Adds a parity bit to the character length |
| mode | input | 2 | 00 async, 01 char-sync, 10 frame mode, 11 char-sync |
| rx_en | input | 1 | Receiver enable |
| auto_en | input | 1 | Gate reception with carrier detect |
| dcd_n | input | 1 | Carrier detect, active low |
| byte_out | output | 8 | Assembled byte |
| byte_push | output | 1 | One-cycle push strobe to the FIFO |
| dcd_status | output | 1 | Registered carrier-detect level |

## Verification
The assertions assume that bit_valid is a plain per-cycle strobe and that reset is asserted long enough to clear every register. They also assume that mode and length inputs hold still in the cycle a bit is accepted. The carrier and enable checks compare a push against the previous cycle's rx_en, auto_en and registered dcd_n, so these controls must come from the same clock domain. The stimulus changes every control at a falling edge only, and it waits several cycles after each enable or carrier change before sending bits. That way the controller has finished GO or STOP before the next bit arrives.

// File: rtl/rx_asm_pkg.sv
package rx_asm_pkg;

    localparam int SR_W     = 9;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_CSYNC = 2'b01,
        MODE_FRAME = 2'b10,
        MODE_RSVD  = 2'b11
    } rx_mode_e;

    typedef enum logic {
        RX_OFF = 1'b0,
        RX_ASM = 1'b1
    } rx_state_e;

endpackage

// File: rtl/rx_en_gate.sv
module rx_en_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic auto_en,
    input  logic dcd_n,
    output logic dcd_q,
    output logic run
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcd_q <= 1'b1;
        end else begin
            dcd_q <= dcd_n;
        end
    end

    always_comb begin
        run = rx_en && (!auto_en || !dcd_q);
    end

endmodule

// File: rtl/rx_bit_counter.sv
module rx_bit_counter
    import rx_asm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             accept,
    input  logic [1:0]       len_code,
    input  logic             par_en,
    output logic [CNT_W-1:0] n_bits,
    output logic             done
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    always_comb begin
        target = CNT_W'(MIN_BITS) + {{(CNT_W-2){1'b0}}, len_code}
                 + {{(CNT_W-1){1'b0}}, par_en};
        n_bits = cnt + CNT_W'(1);
        done   = accept && (n_bits >= target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || done) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= n_bits;
        end
    end

endmodule

// File: rtl/rx_byte_former.sv
module rx_byte_former
    import rx_asm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              bit_in,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  n_bits,
    output logic [BYTE_W-1:0] byte_val
);

    logic [SR_W-1:0]   sr;
    logic [SR_W-1:0]   full;
    logic [SR_W-1:0]   aligned;
    logic [BYTE_W-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (accept) begin
            sr <= full;
        end
    end

    always_comb begin
        full    = {bit_in, sr[SR_W-1:1]};
        aligned = full >> (CNT_W'(SR_W) - n_bits);
        if (n_bits >= CNT_W'(BYTE_W)) begin
            fill = '0;
        end else begin
            fill = {BYTE_W{1'b1}} << n_bits;
        end
        unique case (rx_mode_e'(mode))
            MODE_ASYNC: byte_val = aligned[BYTE_W-1:0] | fill;
            MODE_CSYNC,
            MODE_FRAME,
            MODE_RSVD:  byte_val = full[SR_W-1:SR_W-BYTE_W];
            default:    byte_val = full[SR_W-1:SR_W-BYTE_W];
        endcase
    end

endmodule

// File: rtl/rx_char_assembler.sv
module rx_char_assembler
    import rx_asm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_in,
    input  logic        bit_valid,
    input  logic [1:0]  len_code,
    input  logic        par_en,
    input  logic [1:0]  mode,
    input  logic        rx_en,
    input  logic        auto_en,
    input  logic        dcd_n,
    output logic [7:0]  byte_out,
    output logic        byte_push,
    output logic        dcd_status
);

    rx_state_e         state, state_nx;
    logic              run;
    logic              dcd_q;
    logic              accept;
    logic              clr;
    logic              done;
    logic [CNT_W-1:0]  n_bits;
    logic [BYTE_W-1:0] byte_val;

    rx_en_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .auto_en (auto_en),
        .dcd_n   (dcd_n),
        .dcd_q   (dcd_q),
        .run     (run)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_OFF: if (run)  state_nx = RX_ASM;  // GO
            RX_ASM: if (!run) state_nx = RX_OFF;  // STOP
            default: state_nx = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        accept = (state == RX_ASM) && run && bit_valid;
        clr    = (state == RX_OFF);
    end

    rx_bit_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .accept   (accept),
        .len_code (len_code),
        .par_en   (par_en),
        .n_bits   (n_bits),
        .done     (done)
    );

    rx_byte_former u_form (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .bit_in   (bit_in),
        .mode     (mode),
        .n_bits   (n_bits),
        .byte_val (byte_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_out  <= '0;
            byte_push <= 1'b0;
        end else begin
            byte_push <= done;
            if (done) begin
                byte_out <= byte_val;
            end
        end
    end

    assign dcd_status = dcd_q;

endmodule

// File: rtl/rx_asm_checker.sv
module rx_asm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       rx_en,
    input logic       auto_en,
    input logic       dcd_n,
    input logic       byte_push,
    input logic       dcd_status
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_push_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_push |-> $past(bit_valid));

    assert_push_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_push |-> $past(rx_en));

    assert_push_needs_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_push && $past(auto_en)) |-> !$past(dcd_status));

    assert_push_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_push |=> !byte_push);

    assert_dcd_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (dcd_status == $past(dcd_n)));

endmodule

bind rx_char_assembler rx_asm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .rx_en      (rx_en),
    .auto_en    (auto_en),
    .dcd_n      (dcd_n),
    .byte_push  (byte_push),
    .dcd_status (dcd_status)
);

// File: tb/tb_rx_char_assembler.sv
`timescale 1ns/1ps
module tb_rx_char_assembler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [1:0] len_code = 2'b00;
    logic       par_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       rx_en = 1'b0;
    logic       auto_en = 1'b0;
    logic       dcd_n = 1'b0;
    logic [7:0] byte_out;
    logic       byte_push;
    logic       dcd_status;

    int checks = 0;
    int errors = 0;

    int         mcnt = 0;
    logic [8:0] hist = '0;
    logic [8:0] chr  = '0;

    always #2.5 clk = ~clk;

    rx_char_assembler dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .len_code(len_code), .par_en(par_en), .mode(mode), .rx_en(rx_en),
        .auto_en(auto_en), .dcd_n(dcd_n), .byte_out(byte_out),
        .byte_push(byte_push), .dcd_status(dcd_status)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_run();
        return rx_en && (!auto_en || !dcd_n);
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
        if (!model_run()) begin
            mcnt = 0;
            chr  = '0;
        end
    endtask

    task automatic send_bit(input logic b, input string req);
        logic       exp_push;
        logic [7:0] exp_b;
        int         tgt;
        tgt = 5 + int'(len_code) + int'(par_en);
        exp_push = 1'b0;
        exp_b = '0;
        if (model_run()) begin
            hist = {b, hist[8:1]};
            chr[mcnt] = b;
            mcnt++;
            if (mcnt >= tgt) begin
                exp_push = 1'b1;
                if (mode == 2'b00) begin
                    exp_b = 8'hFF;
                    for (int i = 0; i < 8; i++)
                        if (i < mcnt) exp_b[i] = chr[i];
                end else begin
                    exp_b = hist[8:1];
                end
                mcnt = 0;
                chr  = '0;
            end
        end
        @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        check(byte_push == exp_push, {req, " push"}, int'(byte_push), int'(exp_push));
        if (exp_push)
            check(byte_out == exp_b, {req, " byte"}, int'(byte_out), int'(exp_b));
    endtask

    task automatic send_word(input int v, input int nb, input string req);
        for (int j = 0; j < nb; j++) send_bit(v[j], req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values, with dcd_n low during reset
        check(byte_push == 1'b0, "R1 push", int'(byte_push), 0);
        check(byte_out == 8'h00, "R1 byte", int'(byte_out), 0);
        check(dcd_status == 1'b1, "R1 dcd", int'(dcd_status), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: status follows dcd_n one clock later
        dcd_n = 1'b1;
        @(negedge clk);
        check(dcd_status == 1'b1, "R8 high", int'(dcd_status), 1);
        dcd_n = 1'b0;
        @(negedge clk);
        check(dcd_status == 1'b0, "R8 low", int'(dcd_status), 0);

        rx_en = 1'b1;
        settle();
        // R2 R3 R4: sweep modes, lengths, parity
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 4; l++) begin
                for (int p = 0; p < 2; p++) begin
                    mode = 2'(m);
                    len_code = 2'(l);
                    par_en = 1'(p);
                    @(negedge clk);
                    for (int k = 0; k < 3; k++) begin
                        send_word(m * 37 + l * 11 + p * 5 + k * 93 + 17,
                                  5 + l + p,
                                  (m == 0) ? "R3 R2 async" : "R4 R2 sync");
                    end
                end
            end
        end

        // R5: length change mid-character, async and sync
        for (int m = 0; m < 2; m++) begin
            mode = 2'(m);
            par_en = 1'b0;
            len_code = 2'b11;
            send_word(9'h0B5, 5, "R5 before shrink");
            len_code = 2'b01;
            send_word(9'h1, 1, "R5 shrink pending");
            len_code = 2'b11;
            send_word(9'h02D, 6, "R5 before late shrink");
            len_code = 2'b00;
            send_word(9'h1, 1, "R5 late shrink");
            len_code = 2'b00;
            send_word(9'h03, 3, "R5 before grow");
            par_en = 1'b1;
            send_word(9'h15, 3, "R5 grow");
        end

        // R6: disable mid-character then re-enable
        mode = 2'b00;
        len_code = 2'b10;
        par_en = 1'b0;
        send_word(9'h07, 3, "R6 partial");
        rx_en = 1'b0;
        settle();
        send_word(9'h1FF, 9, "R6 ignored");
        rx_en = 1'b1;
        settle();
        send_word(9'h052, 7, "R6 fresh");
        mode = 2'b01;
        send_word(9'h0AA, 7, "R6 sync history");

        // R7: carrier gating
        mode = 2'b00;
        len_code = 2'b00;
        auto_en = 1'b1;
        dcd_n = 1'b1;
        settle();
        send_word(9'h1F, 6, "R7 carrier off");
        dcd_n = 1'b0;
        settle();
        send_word(9'h0A, 5, "R7 carrier on");
        auto_en = 1'b0;
        dcd_n = 1'b1;
        settle();
        send_word(9'h13, 5, "R7 gating off");

        // R9: pulse lasts one cycle
        send_word(9'h0C, 5, "R9 pulse");
        @(negedge clk);
        check(byte_push == 1'b0, "R9 single", int'(byte_push), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule